// File: doc/BRIEF.md
# Supply Interruption Command Qualifier

This block turns deliberate interruptions of a supply into discrete command events. It watches a "supply present" level that arrives with no timing relation to the clock. It measures each outage in ticks of a slow enable. It then sorts each outage into one of three outcomes by its length.

An outage shorter than the qualification time is treated as noise, such as a moving load briefly losing contact, and produces nothing. An outage that reaches the qualification time produces a single one-cycle advance strobe at the moment it qualifies, which downstream logic uses to step its state. An outage that reaches the long limit produces a one-cycle reset strobe when the supply comes back, which forces the downstream logic to its initial state.

Downstream state is expected to persist through every outage shorter than the long limit. Both limits are parameters in ticks. The outage counter saturates at the long limit.

Top module: `supply_event_qualifier`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it, both strobes are low and the outage count is zero; the synchroniser resets to "supply present".
- R2: `pwrOkAsync` passes through a two-flop synchroniser, so an outage that begins just after clock edge c is first counted at edge c+3.
- R3: An outage that spans fewer than `GLITCH_TICKS` counted ticks produces neither strobe, either during the outage or after it ends.
- R4: An outage that reaches `GLITCH_TICKS` counted ticks raises `advanceStrobe` for exactly one cycle, registered at the edge that counts the `GLITCH_TICKS`-th tick.
- R5: Ticks are counted only in cycles where `tickEn` is high; an outage of any length with `tickEn` held low produces no strobe.
- R6: When the supply returns after the count has reached `LONG_TICKS`, `resetStrobe` is high for exactly one cycle, registered at the first edge that sees the synchronised supply present; no advance strobe is issued on restore.
- R7: An outage that ends with a count of at least `GLITCH_TICKS` and below `LONG_TICKS` gives no reset strobe.
- R8: The count saturates at `LONG_TICKS`. Extending an outage past that limit adds no further strobe, and the outage still yields a single reset strobe.
- R9: The count clears while the supply is present, so each outage is measured afresh; two short outages never add up to a qualified one.
- R10: `advanceStrobe` and `resetStrobe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwrOkAsync | input | 1 | Supply present level, asynchronous, high when present |
| tickEn | input | 1 | Time-base enable; each high cycle during an outage is one tick |
| advanceStrobe | output | 1 | One-cycle pulse when an outage qualifies |
| resetStrobe | output | 1 | One-cycle pulse on restore after a long outage |

## Verification
The properties assume that `GLITCH_TICKS` is at least 1 and below `LONG_TICKS`. They also assume that any supply change the design should see is held for at least two clocks, so that it clears the synchroniser. The stimulus changes `pwrOkAsync` only on falling clock edges and holds each level for whole cycles. It runs with `tickEn` held high, so that ticks equal cycles, except in one outage that holds `tickEn` low to exercise the enable. Outage lengths sit just below, at and above each limit.

// File: rtl/supply_event_pkg.sv
package supply_event_pkg;
  // Control-to-datapath strobes for the outage counter.
  typedef struct packed {
    logic incr;
    logic clear;
  } cnt_ctrl_t;
endpackage

// File: rtl/supply_sync.sv
module supply_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);
  logic [SYNC_STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b1;
    else     chain[0] <= asyncIn;
  end

  genvar s;
  generate
    for (s = 1; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= 1'b1;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign syncOut = chain[SYNC_STAGES-1];
endmodule

// File: rtl/supply_event_datapath.sv
module supply_event_datapath
  import supply_event_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_ctrl_t        cntCtrl,
  output logic [CNT_W-1:0] outageCnt
);
  always_ff @(posedge clk) begin
    if (rst)                outageCnt <= '0;
    else if (cntCtrl.clear) outageCnt <= '0;
    else if (cntCtrl.incr)  outageCnt <= outageCnt + 1'b1;
  end
endmodule

// File: rtl/supply_event_control.sv
module supply_event_control
  import supply_event_pkg::*;
#(
  parameter int GLITCH_TICKS = 8,
  parameter int LONG_TICKS   = 40,
  parameter int CNT_W        = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwrSync,
  input  logic             tickEn,
  input  logic [CNT_W-1:0] outageCnt,
  output cnt_ctrl_t        cntCtrl,
  output logic             advanceStrobe,
  output logic             resetStrobe
);
  localparam logic [CNT_W-1:0] QUAL_M1  = CNT_W'(GLITCH_TICKS - 1);
  localparam logic [CNT_W-1:0] LONG_LIM = CNT_W'(LONG_TICKS);

  logic atLimit;
  assign atLimit = (outageCnt == LONG_LIM);

  always_comb begin
    cntCtrl.clear = pwrSync;
    cntCtrl.incr  = !pwrSync && tickEn && !atLimit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      advanceStrobe <= 1'b0;
      resetStrobe   <= 1'b0;
    end else begin
      advanceStrobe <= cntCtrl.incr && (outageCnt == QUAL_M1);
      resetStrobe   <= pwrSync && atLimit;
    end
  end
endmodule

// File: rtl/supply_event_qualifier.sv
module supply_event_qualifier
  import supply_event_pkg::*;
#(
  parameter int GLITCH_TICKS = 8,
  parameter int LONG_TICKS   = 40,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwrOkAsync,
  input  logic tickEn,
  output logic advanceStrobe,
  output logic resetStrobe
);
  localparam int CNT_W = $clog2(LONG_TICKS + 1);

  logic             pwrSync;
  logic [CNT_W-1:0] outageCnt;
  cnt_ctrl_t        cntCtrl;

  supply_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .asyncIn(pwrOkAsync), .syncOut(pwrSync)
  );

  supply_event_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .cntCtrl(cntCtrl), .outageCnt(outageCnt)
  );

  supply_event_control #(
    .GLITCH_TICKS(GLITCH_TICKS), .LONG_TICKS(LONG_TICKS), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .pwrSync(pwrSync), .tickEn(tickEn),
    .outageCnt(outageCnt), .cntCtrl(cntCtrl),
    .advanceStrobe(advanceStrobe), .resetStrobe(resetStrobe)
  );
endmodule

// File: rtl/supply_event_qualifier_chk.sv
module supply_event_qualifier_chk #(
  parameter int LONG_TICKS = 40,
  parameter int CNT_W      = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             advanceStrobe,
  input logic             resetStrobe,
  input logic             pwrSync,
  input logic [CNT_W-1:0] outageCnt
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!advanceStrobe && !resetStrobe && outageCnt == '0));

  assert_adv_needs_outage_R3: assert property (@(posedge clk) disable iff (rst)
    advanceStrobe |-> !$past(pwrSync));

  assert_adv_single_R4: assert property (@(posedge clk) disable iff (rst)
    advanceStrobe |=> !advanceStrobe);

  assert_rst_single_R6: assert property (@(posedge clk) disable iff (rst)
    resetStrobe |=> !resetStrobe);

  assert_cnt_saturates_R8: assert property (@(posedge clk) disable iff (rst)
    outageCnt <= CNT_W'(LONG_TICKS));

  assert_cnt_clears_R9: assert property (@(posedge clk) disable iff (rst)
    pwrSync |=> (outageCnt == '0));

  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(advanceStrobe && resetStrobe));
endmodule

bind supply_event_qualifier supply_event_qualifier_chk #(
  .LONG_TICKS(LONG_TICKS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .advanceStrobe(advanceStrobe), .resetStrobe(resetStrobe),
  .pwrSync(pwrSync), .outageCnt(outageCnt)
);

// File: tb/tb_supply_event_qualifier.sv
module tb_supply_event_qualifier;
  localparam int G = 8;
  localparam int L = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwrOkAsync = 1'b1;
  logic tickEn = 1'b1;
  logic advanceStrobe, resetStrobe;

  always #2.5 clk = ~clk;

  supply_event_qualifier #(.GLITCH_TICKS(G), .LONG_TICKS(L)) dut (
    .clk(clk), .rst(rst), .pwrOkAsync(pwrOkAsync), .tickEn(tickEn),
    .advanceStrobe(advanceStrobe), .resetStrobe(resetStrobe)
  );

  typedef struct {
    int    kind;   // 1 = advance, 2 = reset
    int    cyc;
    string req;
  } exp_t;

  exp_t  expQ[$];
  int    cyc = 0;
  int    testsRun = 0;
  int    testsFailed = 0;
  string curReq = "R1";
  bit    finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares produced strobes with the scoreboard queue.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (advanceStrobe && resetStrobe) begin
          testsRun++; testsFailed++;
          $display("FAIL R10: both strobes high at cycle %0d (expected at most one)", cyc);
        end
        if (expQ.size() > 0 && expQ[0].cyc < cyc) begin
          exp_t m;
          m = expQ.pop_front();
          testsRun++; testsFailed++;
          $display("FAIL %s: strobe kind %0d missing, actual none, expected at cycle %0d", m.req, m.kind, m.cyc);
        end
        if (advanceStrobe || resetStrobe) begin
          int k;
          k = advanceStrobe ? 1 : 2;
          testsRun++;
          if (expQ.size() == 0) begin
            testsFailed++;
            $display("FAIL %s: unexpected strobe kind %0d at cycle %0d, expected none", curReq, k, cyc);
          end else begin
            exp_t e;
            e = expQ.pop_front();
            if (e.kind != k || e.cyc != cyc) begin
              testsFailed++;
              $display("FAIL %s: strobe kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                       e.req, k, cyc, e.kind, e.cyc);
            end
          end
        end
      end
    end
  end

  // Driver: one outage of n cycles, expected strobes pushed from the requirements.
  task automatic outage(input int n, input bit ticks, input string req);
    int c;
    curReq = req;
    @(negedge clk);
    tickEn = ticks;
    c = cyc;
    pwrOkAsync = 1'b0;
    // R2: first counted edge is c+3, so the G-th tick lands on edge c+2+G.
    if (ticks && n >= G) expQ.push_back('{1, c + 2 + G, req});
    // R6: restore seen by the counter logic at edge c+n+3.
    if (ticks && n >= L) expQ.push_back('{2, c + n + 3, req});
    repeat (n) @(negedge clk);
    pwrOkAsync = 1'b1;
    repeat (8) @(negedge clk);
    tickEn = 1'b1;
    testsRun++;
    if (expQ.size() != 0) begin
      testsFailed++;
      $display("FAIL %s: %0d expected strobes not seen, expected 0 pending", req, expQ.size());
      expQ.delete();
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testsRun++;
    if (advanceStrobe !== 1'b0 || resetStrobe !== 1'b0) begin
      testsFailed++;
      $display("FAIL R1: strobes in reset adv=%b rst=%b, expected 0 0", advanceStrobe, resetStrobe);
    end
    rst = 1'b0;
    repeat (4) @(negedge clk);

    outage(1,   1'b1, "R3");   // single-cycle glitch
    outage(3,   1'b1, "R3");
    outage(G-1, 1'b1, "R3");   // just short of qualifying
    outage(G,   1'b1, "R4");   // exactly qualifies
    outage(20,  1'b1, "R7");   // advance, no reset
    outage(L-1, 1'b1, "R7");   // one short of the long limit
    outage(L,   1'b1, "R6");   // advance then reset on restore
    outage(100, 1'b1, "R8");   // saturated, still one of each
    outage(60,  1'b0, "R5");   // no ticks, nothing
    outage(G-2, 1'b1, "R9");   // two short outages do not add up
    outage(G-2, 1'b1, "R9");
    outage(G,   1'b1, "R9");   // fresh count still qualifies
    outage(2,   1'b1, "R2");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: run did not complete, actual hung, expected finish");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule